// File: doc/BRIEF.md
# Multiplexed Burst Pseudo-SRAM Device Controller

This block is the device-side control logic of a 16-bit pseudo-static RAM that shares one bus for address and data. It samples the chip-enable, address-valid, output-enable, write-enable, control-register-enable and two byte-enable strobes on the rising clock. It then serves array reads and writes, or reads and writes of two configuration registers. A 256-word storage array stands in for the memory core. The bus is split into an input word, an output word and an output enable, so the enclosing pad logic can build the tri-state pins.

A mode bit in the bus configuration register chooses between single asynchronous accesses and clocked bursts. In a single access the captured address stays fixed. In a burst the block first holds WAIT for a programmable number of clocks. After that it moves one word per clock and steps through consecutive addresses, wrapping at the end of the array. WAIT has a programmable polarity. A deep power-down state is armed through the refresh configuration register and is entered and left on chip-enable edges. On the way out the array contents are lost.

Top module: `psram_mux_ctrl`

## Requirements
- R1: After reset the bus configuration register (BCR) reads 16'hFFFF and the refresh configuration register (RCR) reads 16'h0010. The block starts in asynchronous mode with active-high WAIT and a latency of 3.
- R2: When BCR bit 15 is 1, an access is a single access. An address cycle (ce_n=0, adv_n=0) captures the address from adq_i[7:0]. Each later clock with adv_n=1 and we_n=0 writes that same address. While oe_n=0 and we_n=1, the word at that address is driven. WAIT stays deasserted throughout.
- R3: Byte enables are active low. lb_n selects bits 7:0 and ub_n selects bits 15:8. A write changes only the enabled lanes. On a read, a disabled lane is driven as zero.
- R4: When BCR bit 15 is 0, an array address cycle starts a burst. After the latency, each clock with adv_n=1 moves to the next address. Address 255 is followed by address 0.
- R5: The burst latency L is BCR bits 12:11. WAIT is asserted for exactly the L clocks after the address capture, and then deasserted while the burst runs.
- R6: BCR bit 10 sets WAIT polarity. With 1, a high level means data is not valid. With 0, a low level means data is not valid.
- R7: While ce_n=1, adq_oe and wait_oe are 0, all other bus inputs have no effect on the array or the registers, and any burst in progress ends.
- R8: An address cycle with cre=1 selects a register through adq_i[8] (0 = RCR, 1 = BCR). The selected register is written with the whole adq_i word on a later clock with adv_n=1 and we_n=0. It is driven on adq_o while oe_n=0 and we_n=1. Register accesses never wait.
- R9: If RCR bit 4 is 0 when ce_n rises, deep power-down is entered. During deep power-down both output enables are 0 and every input except ce_n is ignored.
- R10: Deep power-down ends at the next clock where ce_n is seen falling. That clock also clears every array word to zero and sets RCR bit 4 back to 1.
- R11: When the address cycle of a burst has we_n=0, the burst is a write burst. After the latency, each clock stores adq_i, under the byte enables, at the current address and then advances the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| cre | input | 1 | Configuration register enable, active high |
| lb_n | input | 1 | Lower byte enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| adq_i | input | 16 | Address/data word from the bus |
| adq_o | output | 16 | Read data or register value to the bus |
| adq_oe | output | 1 | Drive enable for adq_o |
| wait_o | output | 1 | Data-not-ready indication, programmable polarity |
| wait_oe | output | 1 | Drive enable for wait_o |

## Verification
The stimulus covers several kinds of access. Single writes and reads in asynchronous mode confirm that the address never moves. Writes with only one byte lane enabled expose lane-mask errors. Bursts that start near address 255 show the counter wrapping and the exact clock on which WAIT releases. The same bursts are repeated with latencies of 3, 1 and 0 and with both WAIT polarities. A burst write followed by a burst read, cut short by chip-enable, separates write-path faults from read-path faults. Strobes applied while chip-enable is high, and a full deep power-down cycle followed by register and array read-back, check that ignored inputs really leave the state untouched and that the array is cleared on exit.

// File: rtl/psram_mux_ctrl.sv
`timescale 1ns/1ps
module psram_mux_ctrl #(
  parameter int DEPTH   = 256,
  parameter int SEL_BIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        adv_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic        cre,
  input  logic        lb_n,
  input  logic        ub_n,
  input  logic [15:0] adq_i,
  output logic [15:0] adq_o,
  output logic        adq_oe,
  output logic        wait_o,
  output logic        wait_oe
);
  localparam int AW       = $clog2(DEPTH);
  localparam int MODE_BIT = 15;
  localparam int POL_BIT  = 10;
  localparam int LAT_LO   = 11;
  localparam int DPD_BIT  = 4;

  logic [15:0]   mem [DEPTH];
  logic [15:0]   bcr, rcr;
  logic [AW-1:0] addr;
  logic [1:0]    lat_cnt;
  logic          cfg_acc, cfg_sel, op_wr, burst_q, in_acc, dpd, ce_q;
  logic          start_burst, busy;
  logic [15:0]   rd_word;

  assign start_burst = !bcr[MODE_BIT] && !cre;
  assign busy        = in_acc && (lat_cnt != 2'd0);
  assign rd_word     = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcr     <= 16'hFFFF;
      rcr     <= 16'h0010;
      addr    <= '0;
      lat_cnt <= '0;
      cfg_acc <= 1'b0;
      cfg_sel <= 1'b0;
      op_wr   <= 1'b0;
      burst_q <= 1'b0;
      in_acc  <= 1'b0;
      dpd     <= 1'b0;
      ce_q    <= 1'b1;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      ce_q <= ce_n;
      if (dpd) begin
        if (ce_q && !ce_n) begin
          dpd          <= 1'b0;
          rcr[DPD_BIT] <= 1'b1;
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end
      end else if (ce_n) begin
        in_acc <= 1'b0;
        if (!ce_q && !rcr[DPD_BIT]) dpd <= 1'b1;
      end else if (!adv_n) begin
        in_acc  <= 1'b1;
        addr    <= adq_i[AW-1:0];
        cfg_acc <= cre;
        cfg_sel <= adq_i[SEL_BIT];
        op_wr   <= !we_n;
        burst_q <= start_burst;
        lat_cnt <= start_burst ? bcr[LAT_LO+1:LAT_LO] : 2'd0;
      end else if (in_acc) begin
        if (lat_cnt != 2'd0) begin
          lat_cnt <= lat_cnt - 2'd1;
        end else if (cfg_acc) begin
          if (!we_n) begin
            if (cfg_sel) bcr <= adq_i;
            else         rcr <= adq_i;
          end
        end else if (burst_q ? op_wr : !we_n) begin
          if (!lb_n) mem[addr][7:0]  <= adq_i[7:0];
          if (!ub_n) mem[addr][15:8] <= adq_i[15:8];
          if (burst_q) addr <= addr + 1'b1;
        end else if (burst_q) begin
          addr <= addr + 1'b1;
        end
      end
    end
  end

  assign adq_o   = cfg_acc ? (cfg_sel ? bcr : rcr)
                           : {ub_n ? 8'h00 : rd_word[15:8], lb_n ? 8'h00 : rd_word[7:0]};
  assign adq_oe  = !dpd && !ce_n && in_acc && adv_n && !oe_n && we_n;
  assign wait_oe = !dpd && !ce_n;
  assign wait_o  = bcr[POL_BIT] ? busy : !busy;

  AST_DPD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!dpd && !ce_q && ce_n && !rcr[DPD_BIT]) |=> dpd); // R9
  AST_DPD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (dpd && ce_q && !ce_n) |=> (!dpd && rcr[DPD_BIT])); // R10
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!dpd && !ce_n && adv_n && in_acc && burst_q && lat_cnt == 2'd0)
      |=> (addr == AW'($past(addr) + 1'b1))); // R4
  AST_LAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dpd && !ce_n && !adv_n && !bcr[MODE_BIT] && !cre)
      |=> (lat_cnt == $past(bcr[LAT_LO+1:LAT_LO]))); // R5
  AST_STANDBY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!dpd && ce_n) |=> !in_acc); // R7
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dpd && !ce_n && adv_n && in_acc && !burst_q) |=> $stable(addr)); // R2
endmodule

// File: tb/psram_mux_ctrl_tb_top.sv
`timescale 1ns/1ps
module psram_mux_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, cre = 1'b0;
  logic lb_n = 1'b0, ub_n = 1'b0;
  logic [15:0] adq_i = '0;
  logic [15:0] adq_o;
  logic adq_oe, wait_o, wait_oe;

  int n_vec = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  psram_mux_ctrl dut_i (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
    .we_n(we_n), .cre(cre), .lb_n(lb_n), .ub_n(ub_n), .adq_i(adq_i), .adq_o(adq_o),
    .adq_oe(adq_oe), .wait_o(wait_o), .wait_oe(wait_oe));

  int m_mem[256];
  int m_bcr, m_rcr, m_addr, m_lat;
  bit m_cfg, m_sel, m_wr, m_burst, m_in, m_dpd, m_ceq;

  task automatic model_reset();
    foreach (m_mem[i]) m_mem[i] = 0;
    m_bcr = 'hFFFF; m_rcr = 'h0010; m_addr = 0; m_lat = 0;
    m_cfg = 0; m_sel = 0; m_wr = 0; m_burst = 0; m_in = 0; m_dpd = 0; m_ceq = 1;
  endtask

  function automatic int lane_mask();
    return (ub_n ? 0 : 'hFF00) | (lb_n ? 0 : 'h00FF);
  endfunction

  task automatic check(string what, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  task automatic compare();
    bit e_oe, e_woe, e_busy, e_wait;
    int e_dat;
    e_oe  = !m_dpd && !ce_n && m_in && adv_n && !oe_n && we_n;
    e_woe = !m_dpd && !ce_n;
    e_busy = m_in && (m_lat > 0);
    e_wait = m_bcr[10] ? e_busy : !e_busy;
    check("adq_oe", int'(adq_oe), int'(e_oe));
    check("wait_oe", int'(wait_oe), int'(e_woe));
    if (e_oe) begin
      e_dat = m_cfg ? (m_sel ? m_bcr : m_rcr) : (m_mem[m_addr] & lane_mask());
      check("adq_o", int'(adq_o), e_dat);
    end
    if (e_woe) check("wait_o", int'(wait_o), int'(e_wait));
  endtask

  task automatic model_edge();
    if (m_dpd) begin
      if (m_ceq && !ce_n) begin
        m_dpd = 0; m_rcr = m_rcr | 'h10;
        foreach (m_mem[i]) m_mem[i] = 0;
      end
    end else if (ce_n) begin
      m_in = 0;
      if (!m_ceq && !m_rcr[4]) m_dpd = 1;
    end else if (!adv_n) begin
      m_in = 1; m_addr = adq_i[7:0]; m_cfg = cre; m_sel = adq_i[8]; m_wr = !we_n;
      m_burst = !m_bcr[15] && !cre;
      m_lat = m_burst ? ((m_bcr >> 11) & 3) : 0;
    end else if (m_in) begin
      if (m_lat > 0) m_lat--;
      else if (m_cfg) begin
        if (!we_n) begin if (m_sel) m_bcr = adq_i; else m_rcr = adq_i; end
      end else if (m_burst) begin
        if (m_wr) m_mem[m_addr] = (m_mem[m_addr] & ~lane_mask() & 'hFFFF) | (adq_i & lane_mask());
        m_addr = (m_addr + 1) % 256;
      end else if (!we_n) begin
        m_mem[m_addr] = (m_mem[m_addr] & ~lane_mask() & 'hFFFF) | (adq_i & lane_mask());
      end
    end
    m_ceq = ce_n;
  endtask

  task automatic cyc(bit c, bit a, bit o, bit w, bit r, bit lb, bit ub, logic [15:0] d);
    @(negedge clk);
    ce_n = c; adv_n = a; oe_n = o; we_n = w; cre = r; lb_n = lb; ub_n = ub; adq_i = d;
    #1 compare();
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 1, 0, 0, 0, 16'h0);
  endtask

  task automatic reg_write(bit sel, logic [15:0] v);
    cyc(0, 0, 1, 0, 1, 0, 0, {7'h0, sel, 8'h00});
    cyc(0, 1, 1, 0, 0, 0, 0, v);
    idle(1);
  endtask

  task automatic reg_read(bit sel);
    cyc(0, 0, 1, 1, 1, 0, 0, {7'h0, sel, 8'h00});
    cyc(0, 1, 0, 1, 0, 0, 0, 16'h0);
    idle(1);
  endtask

  task automatic single_write(int a, logic [15:0] v, bit lb, bit ub);
    cyc(0, 0, 1, 0, 0, 0, 0, 16'(a));
    cyc(0, 1, 1, 0, 0, lb, ub, v);
    cyc(0, 1, 1, 0, 0, lb, ub, v);
    idle(1);
  endtask

  task automatic single_read(int a, bit lb, bit ub);
    cyc(0, 0, 1, 1, 0, 0, 0, 16'(a));
    cyc(0, 1, 0, 1, 0, lb, ub, 16'h0);
    cyc(0, 1, 0, 1, 0, lb, ub, 16'h0);
    idle(1);
  endtask

  task automatic burst_read(int a, int n);
    cyc(0, 0, 1, 1, 0, 0, 0, 16'(a));
    for (int i = 0; i < n; i++) cyc(0, 1, 0, 1, 0, 0, 0, 16'h0);
    idle(1);
  endtask

  task automatic burst_write(int a, int n, logic [15:0] base);
    cyc(0, 0, 1, 0, 0, 0, 0, 16'(a));
    for (int i = 0; i < n; i++) cyc(0, 1, 1, 1, 0, 0, 0, base + 16'(i * 16'h0101));
    idle(1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(2);
    reg_read(1); reg_read(0);
    cur_req = "R2"; single_write(5, 16'h1234, 0, 0); single_read(5, 0, 0);
    cur_req = "R3"; single_write(6, 16'hAAAA, 0, 1);
    single_read(6, 0, 0); single_read(6, 1, 0); single_read(6, 0, 1);
    single_write(5, 16'hBE00, 1, 0); single_read(5, 0, 0);
    cur_req = "R7";
    cyc(1, 0, 1, 0, 1, 0, 0, 16'h0105); cyc(1, 1, 1, 0, 0, 0, 0, 16'hDEAD);
    single_read(5, 0, 0); reg_read(1);
    cur_req = "R2";
    for (int k = 0; k < 10; k++) single_write((250 + k) % 256, 16'hC000 + 16'(k * 17), 0, 0);
    cur_req = "R8"; reg_write(1, 16'h7FFF); reg_read(1);
    cur_req = "R4"; burst_read(252, 12);
    cur_req = "R5"; burst_read(0, 4);
    cur_req = "R6"; reg_write(1, 16'h6BFF); reg_read(1); burst_read(254, 5);
    cur_req = "R11"; burst_write(254, 4, 16'h1111); burst_read(254, 6);
    cur_req = "R7";
    cyc(0, 0, 1, 1, 0, 0, 0, 16'd10);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 1, 0, 0, 0, 16'h0);
    idle(2); burst_read(12, 2);
    cur_req = "R5"; reg_write(1, 16'h67FF); burst_read(250, 4);
    cur_req = "R3"; burst_write(3, 2, 16'h00F0);
    cur_req = "R9"; reg_write(0, 16'h0000); reg_read(0);
    idle(2);
    cyc(1, 0, 0, 0, 1, 0, 0, 16'h0100); idle(2);
    cur_req = "R10";
    cyc(0, 0, 1, 0, 1, 0, 0, 16'h0100);
    cyc(0, 1, 1, 0, 0, 0, 0, 16'h5555);
    idle(2);
    reg_read(0); reg_read(1);
    burst_read(250, 8); single_read(5, 0, 0);
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule